// File: doc/BRIEF.md
# Adaptive Idle-Timeout Shutdown Controller

This block watches a one-bit activity signal and decides when a device should be put into a low-power state. It counts consecutive idle cycles. When that count reaches the current timeout, it raises a shutdown request. The request is held until activity comes back. Activity then withdraws the shutdown request and raises a wake request. The wake request is held until the device answers with a wake-done pulse, and the block then returns to counting.

The timeout is not fixed. At reset it is seeded from the break-even time input, which is the idle length needed for a shutdown to pay for its own transitions. When each shutdown ends, its total idle length is graded. A shutdown whose idle length is at least the break-even time is good, and a shorter one is bad. Shutdowns are grouped into windows of a fixed size. A window with too many bad shutdowns doubles the timeout. A window with no bad shutdown halves it. Two saturating counters, one for good shutdowns and one for bad ones, are exposed together with the live timeout value.

Top module: `idle_timeout_ctl`

## Requirements
- R1: While reset is held (synchronous, active low), both requests are low, both statistics counters are zero, and the timeout is loaded with breakEven limited to the range [TO_MIN, TO_MAX].
- R2: With activity low from a running start, sleepReq rises exactly after the edge that samples the timeout-th consecutive idle cycle, and not one cycle earlier.
- R3: Activity sampled while not shut down restarts the idle count from zero.
- R4: Activity sampled while sleepReq is high drops sleepReq and raises wakeReq on the next cycle.
- R5: wakeReq stays high until wakeDone is sampled high, after which the block returns to running. sleepReq and wakeReq are never high together.
- R6: The idle length of a shutdown is the number of idle cycles sampled between the last activity before it and the activity that ends it. A length of at least breakEven increments goodCount, and a shorter length increments badCount.
- R7: At the end of every window of WIN shutdowns, if more than BAD_LIM of them were bad, the timeout doubles, limited to TO_MAX.
- R8: At the end of a window with no bad shutdown, the timeout halves (shift right by one), limited below by TO_MIN.
- R9: At the end of a window with between 1 and BAD_LIM bad shutdowns, the timeout is unchanged.
- R10: goodCount and badCount saturate at their all-ones value.
- R11: The timeout changes only on the cycle that ends a shutdown, and it always stays within [TO_MIN, TO_MAX].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| active | input | 1 | Device activity; high means busy |
| breakEven | input | CNT_W | Break-even idle length in cycles |
| wakeDone | input | 1 | Device reports that the wake-up has completed |
| sleepReq | output | 1 | Shutdown request |
| wakeReq | output | 1 | Wake request |
| timeoutNow | output | CNT_W | Current idle timeout in cycles |
| goodCount | output | STAT_W | Saturating count of good shutdowns |
| badCount | output | STAT_W | Saturating count of bad shutdowns |

## Verification
The checker watches these properties on every cycle:
- the two requests are mutually exclusive;
- activity ends a shutdown request with an immediate hand-over to wake;
- the wake request holds until wakeDone is seen;
- the timeout stays within its bounds and moves only when a shutdown ends;
- each statistics counter either holds or steps by exactly one.

The directed scenarios cover the behaviours that depend on history:
- the exact cycle on which the idle count reaches the timeout, and the restart of that count by activity;
- the grading of idle lengths against break-even;
- the doubling, halving and no-change outcomes at the end of a window, including the upper and lower limits;
- counter saturation.

// File: rtl/ito_pkg.sv
package ito_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic clrIdle;
    logic incIdle;
    logic judge;
  } ctlStrobe_t;
endpackage

// File: rtl/ito_sat_counter.sv
module ito_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (bump && (cnt != TOP)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ito_ctrl.sv
module ito_ctrl
  import ito_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       wakeDone,
  input  logic       toHit,
  output ctlStrobe_t strobe,
  output logic       sleepReq,
  output logic       wakeReq
);
  ctlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_RUN: begin
        if (active) begin
          strobe.clrIdle = 1'b1;
        end else begin
          strobe.incIdle = 1'b1;
          if (toHit) stateNext = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (active) begin
          strobe.judge = 1'b1;
          stateNext    = ST_WAKE;
        end else begin
          strobe.incIdle = 1'b1;
        end
      end
      ST_WAKE: begin
        strobe.clrIdle = 1'b1;
        if (wakeDone) stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= stateNext;
  end

  assign sleepReq = (state == ST_SLEEP);
  assign wakeReq  = (state == ST_WAKE);
endmodule

// File: rtl/ito_datapath.sv
module ito_datapath
  import ito_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int STAT_W  = 8,
  parameter int WIN     = 8,
  parameter int BAD_LIM = 2,
  parameter int TO_MIN  = 4,
  parameter int TO_MAX  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic [CNT_W-1:0]  breakEven,
  output logic              toHit,
  output logic [CNT_W-1:0]  timeoutNow,
  output logic [STAT_W-1:0] goodCount,
  output logic [STAT_W-1:0] badCount
);
  localparam int WIN_W  = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int BAD_W  = $clog2(WIN + 1);
  localparam logic [CNT_W-1:0] MIN_V   = CNT_W'(TO_MIN);
  localparam logic [CNT_W-1:0] MAX_V   = CNT_W'(TO_MAX);
  localparam logic [CNT_W-1:0] IDLE_TOP = '1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN - 1);
  localparam logic [BAD_W-1:0] BAD_LIM_V = BAD_W'(BAD_LIM);

  logic [CNT_W-1:0] idleCnt, idleNext, timeoutReg;
  logic [WIN_W-1:0] winCnt;
  logic [BAD_W-1:0] winBad, badNow;
  logic             isGood, winLast;
  logic [CNT_W:0]   dblWide;
  logic [CNT_W-1:0] dblTo, halfTo;
  logic [1:0]       bumpVec;

  function automatic logic [CNT_W-1:0] clampTo(input logic [CNT_W-1:0] v);
    if (v < MIN_V)      return MIN_V;
    else if (v > MAX_V) return MAX_V;
    else                return v;
  endfunction

  // idle run length, saturating
  assign idleNext = (idleCnt == IDLE_TOP) ? idleCnt : idleCnt + 1'b1;
  assign toHit    = (idleNext >= timeoutReg);

  always_ff @(posedge clk) begin
    if (!rst_n)              idleCnt <= '0;
    else if (strobe.clrIdle) idleCnt <= '0;
    else if (strobe.incIdle) idleCnt <= idleNext;
  end

  // grading and window bookkeeping
  assign isGood  = (idleCnt >= breakEven);
  assign badNow  = winBad + (isGood ? BAD_W'(0) : BAD_W'(1));
  assign winLast = (winCnt == WIN_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      winCnt <= '0;
      winBad <= '0;
    end else if (strobe.judge) begin
      if (winLast) begin
        winCnt <= '0;
        winBad <= '0;
      end else begin
        winCnt <= winCnt + 1'b1;
        winBad <= badNow;
      end
    end
  end

  // timeout adaptation
  assign dblWide = {timeoutReg, 1'b0};
  assign dblTo   = (dblWide > {1'b0, MAX_V}) ? MAX_V : dblWide[CNT_W-1:0];
  assign halfTo  = ((timeoutReg >> 1) < MIN_V) ? MIN_V : (timeoutReg >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timeoutReg <= clampTo(breakEven);
    end else if (strobe.judge && winLast) begin
      if (badNow > BAD_LIM_V)  timeoutReg <= dblTo;
      else if (badNow == '0)   timeoutReg <= halfTo;
    end
  end

  assign timeoutNow = timeoutReg;

  // statistics: index 0 good, index 1 bad
  assign bumpVec[0] = strobe.judge &&  isGood;
  assign bumpVec[1] = strobe.judge && !isGood;

  logic [STAT_W-1:0] statVal [2];

  for (genvar g = 0; g < 2; g++) begin : g_stat
    ito_sat_counter #(.W(STAT_W)) stat_i (
      .clk  (clk),
      .rst_n(rst_n),
      .bump (bumpVec[g]),
      .cnt  (statVal[g])
    );
  end

  assign goodCount = statVal[0];
  assign badCount  = statVal[1];
endmodule

// File: rtl/idle_timeout_ctl.sv
module idle_timeout_ctl
  import ito_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int STAT_W  = 8,
  parameter int WIN     = 8,
  parameter int BAD_LIM = 2,
  parameter int TO_MIN  = 4,
  parameter int TO_MAX  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [CNT_W-1:0]  breakEven,
  input  logic              wakeDone,
  output logic              sleepReq,
  output logic              wakeReq,
  output logic [CNT_W-1:0]  timeoutNow,
  output logic [STAT_W-1:0] goodCount,
  output logic [STAT_W-1:0] badCount
);
  ctlStrobe_t strobe;
  logic       toHit;

  ito_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .wakeDone(wakeDone),
    .toHit   (toHit),
    .strobe  (strobe),
    .sleepReq(sleepReq),
    .wakeReq (wakeReq)
  );

  ito_datapath #(
    .CNT_W  (CNT_W),
    .STAT_W (STAT_W),
    .WIN    (WIN),
    .BAD_LIM(BAD_LIM),
    .TO_MIN (TO_MIN),
    .TO_MAX (TO_MAX)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .breakEven (breakEven),
    .toHit     (toHit),
    .timeoutNow(timeoutNow),
    .goodCount (goodCount),
    .badCount  (badCount)
  );
endmodule

// File: rtl/ito_checker.sv
module ito_checker #(
  parameter int CNT_W  = 16,
  parameter int STAT_W = 8,
  parameter int TO_MIN = 4,
  parameter int TO_MAX = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active,
  input logic              wakeDone,
  input logic              sleepReq,
  input logic              wakeReq,
  input logic [CNT_W-1:0]  timeoutNow,
  input logic [STAT_W-1:0] goodCount,
  input logic [STAT_W-1:0] badCount
);
  // R5
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleepReq && wakeReq));

  // R4
  wake_on_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleepReq && active) |=> (!sleepReq && wakeReq));

  // R5
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wakeReq && !wakeDone) |=> wakeReq);

  // R11
  timeout_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeoutNow >= CNT_W'(TO_MIN)) && (timeoutNow <= CNT_W'(TO_MAX)));

  // R11
  timeout_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(timeoutNow) |-> ($past(sleepReq) && wakeReq));

  // R10
  good_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(goodCount) |-> (goodCount == $past(goodCount) + 1'b1));

  // R10
  bad_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(badCount) |-> (badCount == $past(badCount) + 1'b1));
endmodule

bind idle_timeout_ctl ito_checker #(
  .CNT_W (CNT_W),
  .STAT_W(STAT_W),
  .TO_MIN(TO_MIN),
  .TO_MAX(TO_MAX)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .active    (active),
  .wakeDone  (wakeDone),
  .sleepReq  (sleepReq),
  .wakeReq   (wakeReq),
  .timeoutNow(timeoutNow),
  .goodCount (goodCount),
  .badCount  (badCount)
);

// File: tb/idle_timeout_ctl_tb_top.sv
module idle_timeout_ctl_tb_top;
  localparam int CNT_W  = 12;
  localparam int STAT_W = 4;
  localparam int TO_MIN = 2;
  localparam int TO_MAX = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              active = 1'b1;
  logic [CNT_W-1:0]  breakEven = 12'd20;
  logic              wakeDone = 1'b0;
  logic              sleepReq, wakeReq;
  logic [CNT_W-1:0]  timeoutNow;
  logic [STAT_W-1:0] goodCount, badCount;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  idle_timeout_ctl #(
    .CNT_W  (CNT_W),
    .STAT_W (STAT_W),
    .WIN    (8),
    .BAD_LIM(2),
    .TO_MIN (TO_MIN),
    .TO_MAX (TO_MAX)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .breakEven (breakEven),
    .wakeDone  (wakeDone),
    .sleepReq  (sleepReq),
    .wakeReq   (wakeReq),
    .timeoutNow(timeoutNow),
    .goodCount (goodCount),
    .badCount  (badCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input int be);
    @(negedge clk);
    rst_n = 1'b0;
    active = 1'b1;
    wakeDone = 1'b0;
    breakEven = CNT_W'(be);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 sleepReq", int'(sleepReq), 0);
    chk("R1 wakeReq", int'(wakeReq), 0);
    chk("R1 goodCount", int'(goodCount), 0);
    chk("R1 badCount", int'(badCount), 0);
    rst_n = 1'b1;
  endtask

  // finish a shutdown: activity ends it, wake handshake completes
  task automatic endShutdown(input int holdWake);
    @(negedge clk);
    active = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R4 sleepReq drop", int'(sleepReq), 0);
    chk("R4 wakeReq rise", int'(wakeReq), 1);
    repeat (holdWake) @(posedge clk);
    @(negedge clk);
    chk("R5 wakeReq held", int'(wakeReq), 1);
    wakeDone = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wakeDone = 1'b0;
    chk("R5 back to run", int'(wakeReq), 0);
  endtask

  // one shutdown with n idle cycles (n >= current timeout)
  task automatic doShutdown(input int n);
    @(negedge clk);
    active = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    chk("R2 sleepReq after idle", int'(sleepReq), 1);
    endShutdown(0);
  endtask

  task automatic testTimeoutEdge;
    // timeout 20: nothing after 19 idle cycles, request after 20
    @(negedge clk);
    active = 1'b0;
    repeat (19) @(posedge clk);
    @(negedge clk);
    chk("R2 not early", int'(sleepReq), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 on time", int'(sleepReq), 1);
    endShutdown(3);
    chk("R6 good graded", int'(goodCount), 1);
  endtask

  task automatic testRestart;
    // timeout 10: 9 idle, 1 active, 9 idle must not trip
    @(negedge clk);
    active = 1'b0;
    repeat (9) @(posedge clk);
    @(negedge clk);
    active = 1'b1;
    @(posedge clk);
    @(negedge clk);
    active = 1'b0;
    repeat (9) @(posedge clk);
    @(negedge clk);
    chk("R3 count restarted", int'(sleepReq), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 trips after full run", int'(sleepReq), 1);
    endShutdown(0);
    chk("R6 bad graded", int'(badCount), 1);
  endtask

  initial begin
    doReset(20);
    chk("R1 timeout seed", int'(timeoutNow), 20);

    // window 1: eight good shutdowns -> halve
    testTimeoutEdge();
    for (int i = 0; i < 6; i++) doShutdown(20);
    chk("R11 timeout held mid-window", int'(timeoutNow), 20);
    doShutdown(20);
    chk("R8 halved", int'(timeoutNow), 10);
    chk("R6 good count", int'(goodCount), 8);

    // window 2: two bad -> unchanged
    testRestart();
    doShutdown(10);
    for (int i = 0; i < 6; i++) doShutdown(20);
    chk("R9 unchanged", int'(timeoutNow), 10);
    chk("R6 bad count", int'(badCount), 2);

    // window 3: three bad -> double; good count saturates
    for (int i = 0; i < 3; i++) doShutdown(10);
    for (int i = 0; i < 5; i++) doShutdown(20);
    chk("R7 doubled", int'(timeoutNow), 20);
    chk("R10 good saturates", int'(goodCount), 15);
    chk("R6 bad count w3", int'(badCount), 5);

    // cap: seed above maximum is clamped, doubling stays at max
    doReset(100);
    chk("R1 seed clamped high", int'(timeoutNow), TO_MAX);
    for (int i = 0; i < 8; i++) doShutdown(64);
    chk("R7 capped", int'(timeoutNow), TO_MAX);
    chk("R6 all bad", int'(badCount), 8);
    for (int i = 0; i < 8; i++) doShutdown(64);
    chk("R10 bad saturates", int'(badCount), 15);

    // floor: halving stops at minimum
    doReset(3);
    chk("R1 seed small", int'(timeoutNow), 3);
    for (int i = 0; i < 8; i++) doShutdown(3);
    chk("R8 floored", int'(timeoutNow), TO_MIN);
    for (int i = 0; i < 8; i++) doShutdown(3);
    chk("R8 stays at floor", int'(timeoutNow), TO_MIN);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule